// File: doc/BRIEF.md
# Warp Sector Coalescer

The block takes one memory request from a 32-lane warp. Each lane brings a byte address for a 4-byte element and an active bit. The block folds the active lanes into the fewest 32-byte sector transactions and issues them one per cycle over a valid/ready handshake. Each issued request carries the sector-aligned address, the 4-bit map of sectors touched inside its 128-byte line, and the set of lanes it serves. When the warp is drained, a one-cycle done pulse presents the number of transactions the warp cost.

The controller is a four-state machine:

- `ST_IDLE` accepts a warp: `req_valid` moves it to `ST_PICK`.
- `ST_PICK` selects the line of the lowest-numbered lane still pending. If such a lane exists it moves to `ST_ISSUE`; otherwise it moves to `ST_FINISH`.
- `ST_ISSUE` offers that line's sectors in ascending order. Each handshake retires one sector. After the line's last sector it returns to `ST_PICK`.
- `ST_FINISH` pulses done and returns to `ST_IDLE`.

A warp that covers 32 consecutive aligned words costs four transactions. Strided or scattered lanes cost more.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, and `sec_valid` and `done` are 0.
- R2: Each issued `sec_addr` has bits [4:0] at zero. `sec_lanes` bit i is set exactly for the active, not-yet-served lanes whose address bits [31:5] equal `sec_addr[31:5]`.
- R3: `txn_count` on the done pulse equals the number of distinct 32-byte sectors touched by active lanes. Every active lane appears in exactly one issued `sec_lanes`.
- R4: Lanes with `req_active` bit clear are never listed in `sec_lanes` and add no sectors, whatever their address.
- R5: The next line (address bits [31:7]) is the line of the lowest-numbered pending active lane. Within a line, sectors (address bits [6:5]) are issued in ascending index, and all of a line's sectors are issued before the next line begins.
- R6: `sec_mask` bit s is set when any active lane of the current line touches sector s. The value is identical for every request of that line.
- R7: While `sec_valid` is high and `sec_ready` is low, `sec_valid`, `sec_addr`, `sec_mask` and `sec_lanes` hold their values. At most one sector retires per cycle.
- R8: `req_ready` is 1 only in `ST_IDLE`. It falls on the cycle after acceptance and stays low until the cycle after the done pulse. A held `req_valid` has no effect while busy.
- R9: `done` is a one-cycle pulse, two cycles after the final sector handshake, with `txn_count` valid on it. A warp with no active lanes pulses `done` two cycles after acceptance with a count of 0.
- R10: The first sector is valid on the second cycle after acceptance. Consecutive lines are separated by exactly one cycle with `sec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a warp |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_active | input | LANES | Lane active bits |
| sec_valid | output | 1 | Sector request offered |
| sec_ready | input | 1 | Downstream takes the sector request |
| sec_addr | output | ADDR_W | 32-byte aligned sector address |
| sec_mask | output | 4 | Sectors of the current 128-byte line that are touched |
| sec_lanes | output | LANES | Lanes served by this sector |
| done | output | 1 | Warp finished, one cycle |
| txn_count | output | 6 | Sector transactions of the finished warp |

## Verification
An accepted warp shows its first sector two cycles later. Each later line costs one empty cycle, and `done` arrives two cycles after the last handshake. An empty warp pulses `done` two cycles after acceptance.

The bench turns every accepted warp into an ordered list of expected cycles: empty gaps, sector offers and the done pulse. It advances that list only on clock edges, consuming an offer only when `sec_ready` was high. Outputs are compared at the falling edge against the head of the list, so each result is checked on exactly the cycle it is due, including stalled cycles under random backpressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int SEC_LOG  = 5;
    localparam int LINE_LOG = 7;
    localparam int SEC_PER_LINE = 1 << (LINE_LOG - SEC_LOG);
    localparam int SI_W = LINE_LOG - SEC_LOG;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_ISSUE,
        ST_FINISH
    } coal_state_e;
endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coal_sec_pick.sv
module coal_sec_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  left,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    assign onehot = left & (~left + 1'b1);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (left[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coal_lane_cmp.sv
module coal_lane_cmp
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    localparam int LINE_W = ADDR_W - LINE_LOG
) (
    input  logic [LANES*ADDR_W-1:0] addrs,
    input  logic [LANES-1:0]        pend,
    input  logic [LINE_W-1:0]       ref_line,
    input  logic [SEC_PER_LINE-1:0] sec_sel,
    output logic [LANES-1:0]        line_hit,
    output logic [LANES-1:0]        sec_hit,
    output logic [SEC_PER_LINE-1:0] line_secs
);
    logic [SI_W-1:0] lane_sec [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        assign a           = addrs[g*ADDR_W +: ADDR_W];
        assign lane_sec[g] = a[LINE_LOG-1:SEC_LOG];
        assign line_hit[g] = pend[g] && (a[ADDR_W-1:LINE_LOG] == ref_line);
        assign sec_hit[g]  = line_hit[g] && sec_sel[a[LINE_LOG-1:SEC_LOG]];
    end

    always_comb begin
        line_secs = '0;
        for (int i = 0; i < LANES; i++) begin
            if (line_hit[i]) line_secs[lane_sec[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    localparam int CNT_W  = $clog2(LANES + 1),
    localparam int IW     = $clog2(LANES),
    localparam int LINE_W = ADDR_W - LINE_LOG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_active,
    output logic                    sec_valid,
    input  logic                    sec_ready,
    output logic [ADDR_W-1:0]       sec_addr,
    output logic [SEC_PER_LINE-1:0] sec_mask,
    output logic [LANES-1:0]        sec_lanes,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);
    coal_state_e state_q, state_d;

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pend_q;
    logic [LINE_W-1:0]       line_q;
    logic [SEC_PER_LINE-1:0] lmask_q, left_q;
    logic [CNT_W-1:0]        cnt_q;

    logic                    first_found;
    logic [IW-1:0]           first_idx;
    logic [LINE_W-1:0]       pick_line, ref_line;
    logic [SEC_PER_LINE-1:0] cur_oh, line_secs;
    logic [SI_W-1:0]         cur_idx;
    logic [LANES-1:0]        line_hit, sec_hit;
    logic                    take, last_sec;

    coal_first_lane #(.N(LANES)) u_first (
        .vec   (pend_q),
        .found (first_found),
        .idx   (first_idx)
    );

    coal_sec_pick #(.N(SEC_PER_LINE)) u_sec (
        .left   (left_q),
        .onehot (cur_oh),
        .idx    (cur_idx)
    );

    assign pick_line = addr_q[int'(first_idx)*ADDR_W + LINE_LOG +: LINE_W];
    assign ref_line  = (state_q == ST_PICK) ? pick_line : line_q;

    coal_lane_cmp #(.LANES(LANES), .ADDR_W(ADDR_W)) u_cmp (
        .addrs     (addr_q),
        .pend      (pend_q),
        .ref_line  (ref_line),
        .sec_sel   (cur_oh),
        .line_hit  (line_hit),
        .sec_hit   (sec_hit),
        .line_secs (line_secs)
    );

    assign take     = (state_q == ST_ISSUE) && sec_ready;
    assign last_sec = (left_q == cur_oh);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_PICK;
            ST_PICK:   state_d = first_found ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:  if (take && last_sec) state_d = ST_PICK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pend_q  <= '0;
            line_q  <= '0;
            lmask_q <= '0;
            left_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                pend_q <= req_active;
                cnt_q  <= '0;
            end
            if (state_q == ST_PICK && first_found) begin
                line_q  <= pick_line;
                lmask_q <= line_secs;
                left_q  <= line_secs;
            end
            if (take) begin
                pend_q <= pend_q & ~sec_hit;
                left_q <= left_q & ~cur_oh;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        sec_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_PICK:   ;
            ST_ISSUE:  sec_valid = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign sec_addr  = {line_q, cur_idx, {SEC_LOG{1'b0}}};
    assign sec_mask  = lmask_q;
    assign sec_lanes = sec_hit;
    assign txn_count = cnt_q;

    // R7
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid && !sec_ready |=> sec_valid && $stable(sec_addr)
            && $stable(sec_mask) && $stable(sec_lanes));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R2
    lanes_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> (sec_lanes != '0) && (sec_addr[SEC_LOG-1:0] == '0));

    // R6
    mask_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> sec_mask[sec_addr[LINE_LOG-1:SEC_LOG]]);

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (sec_valid || done)));
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
    localparam int L = 32;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [L*AW-1:0] req_addr = '0;
    logic [L-1:0] req_active = '0;
    logic sec_valid;
    logic sec_ready = 1'b0;
    logic [AW-1:0] sec_addr;
    logic [3:0] sec_mask;
    logic [L-1:0] sec_lanes;
    logic done;
    logic [5:0] txn_count;

    always #2 clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .sec_valid(sec_valid),
        .sec_ready(sec_ready), .sec_addr(sec_addr), .sec_mask(sec_mask),
        .sec_lanes(sec_lanes), .done(done), .txn_count(txn_count)
    );

    localparam logic [1:0] K_GAP = 2'd0, K_SEC = 2'd1, K_DONE = 2'd2;
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [3:0]  mask;
        logic [31:0] lanes;
        logic [5:0]  cnt;
    } exp_t;

    exp_t q[$];
    int unsigned ta [L];
    logic [L-1:0] tact;
    int checks = 0, failures = 0;
    bit finished = 0;
    bit all_ready = 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build();
        logic [L-1:0] pend;
        int total;
        exp_t e;
        pend = tact;
        total = 0;
        e = '0; e.kind = K_GAP; q.push_back(e);
        while (pend != 0) begin
            int f;
            int unsigned ln;
            logic [3:0] m;
            f = 0;
            for (int j = L - 1; j >= 0; j--) if (pend[j]) f = j;
            ln = ta[f] >> 7;
            m = '0;
            for (int j = 0; j < L; j++)
                if (pend[j] && (ta[j] >> 7) == ln) m[(ta[j] >> 5) & 3] = 1'b1;
            for (int s = 0; s < 4; s++) begin
                if (m[s]) begin
                    logic [L-1:0] lz;
                    lz = '0;
                    for (int j = 0; j < L; j++)
                        if (pend[j] && (ta[j] >> 5) == ((ln << 2) | s)) lz[j] = 1'b1;
                    e = '0; e.kind = K_SEC; e.addr = (ln << 7) | (s << 5);
                    e.mask = m; e.lanes = lz;
                    q.push_back(e);
                    total++;
                    pend &= ~lz;
                end
            end
            e = '0; e.kind = K_GAP; q.push_back(e);
        end
        e = '0; e.kind = K_DONE; e.cnt = 6'(total); q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (!rst_n) q.delete();
        else if (q.size() == 0) begin
            if (req_valid) build();
        end else if (q[0].kind == K_SEC) begin
            if (sec_ready) void'(q.pop_front());
        end else void'(q.pop_front());
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q.size() == 0) begin
                chk(req_ready === 1'b1, "R8 ready when idle", 64'(req_ready), 1);
                chk(sec_valid === 1'b0, "R10 no sector when idle", 64'(sec_valid), 0);
                chk(done === 1'b0, "R9 no done when idle", 64'(done), 0);
            end else begin
                chk(req_ready === 1'b0, "R8 ready low while busy", 64'(req_ready), 0);
                case (q[0].kind)
                    K_GAP: begin
                        chk(sec_valid === 1'b0, "R10 gap cycle", 64'(sec_valid), 0);
                        chk(done === 1'b0, "R9 done early", 64'(done), 0);
                    end
                    K_SEC: begin
                        chk(sec_valid === 1'b1, "R10 R7 sector valid due", 64'(sec_valid), 1);
                        chk(sec_addr === q[0].addr, "R2 R5 sector address/order", 64'(sec_addr), 64'(q[0].addr));
                        chk(sec_mask === q[0].mask, "R6 line sector mask", 64'(sec_mask), 64'(q[0].mask));
                        chk(sec_lanes === q[0].lanes, "R2 R4 served lanes", 64'(sec_lanes), 64'(q[0].lanes));
                    end
                    default: begin
                        chk(done === 1'b1, "R9 done pulse", 64'(done), 1);
                        chk(txn_count === q[0].cnt, "R3 transaction count", 64'(txn_count), 64'(q[0].cnt));
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        #1;
        sec_ready = all_ready ? 1'b1 : (($urandom % 3) != 0);
    end

    task automatic pack();
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = ta[i];
        req_active = tact;
    endtask

    task automatic send(input bit hold);
        @(negedge clk); #1;
        pack();
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        if (hold) begin
            for (int i = 0; i < L; i++) ta[i] = 32'h9000_0000 + i * 4;
            pack();
            repeat (3) @(negedge clk);
            #1;
        end
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 values under reset
        chk(req_ready === 1'b1, "R1 ready in reset", 64'(req_ready), 1);
        chk(sec_valid === 1'b0, "R1 valid in reset", 64'(sec_valid), 0);
        chk(done === 1'b0, "R1 done in reset", 64'(done), 0);
        rst_n = 1'b1;

        // R3 contiguous aligned words: four sectors
        for (int i = 0; i < L; i++) ta[i] = 32'h1000 + i * 4;
        tact = '1; send(0);
        // R3 stride of 8 bytes: two lines
        for (int i = 0; i < L; i++) ta[i] = 32'h2000 + i * 8;
        send(0);
        // R3 one sector per lane
        for (int i = 0; i < L; i++) ta[i] = 32'h4000 + i * 32;
        send(0);
        // R2 broadcast
        for (int i = 0; i < L; i++) ta[i] = 32'h5544;
        send(0);
        // R9 empty warp
        tact = '0; send(0);
        // R4 inactive lanes point elsewhere
        for (int i = 0; i < L; i++) ta[i] = (i % 3 == 0) ? 32'h7000 + i * 4 : 32'hF000_0000 + i * 128;
        for (int i = 0; i < L; i++) tact[i] = (i % 3 == 0);
        send(0);
        // R5 interleaved lines, first lane in the higher line
        for (int i = 0; i < L; i++) ta[i] = (i % 2 == 0) ? 32'h8180 + (i % 8) * 4 : 32'h8000 + 96 - (i % 4) * 32;
        tact = '1; send(0);
        // R8 held request while busy
        for (int i = 0; i < L; i++) ta[i] = 32'h3000 + (L - 1 - i) * 4;
        send(1);
        // R7 backpressure with scattered addresses
        all_ready = 0;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < L; i++) ta[i] = ($urandom % 1024) & ~32'h3;
            tact = $urandom;
            send(0);
        end
        for (int i = 0; i < L; i++) ta[i] = 32'h6000 + i * 4;
        tact = '1; send(0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule